// File: doc/BRIEF.md
# Sleep Power State Controller

This block follows a processor's power state around a sleep instruction. When the core raises a sleep request while running, the block reads one selector bit from each of two standby-control bytes. It then moves to one of three low-power states: plain sleep, deep sleep or standby. Each of those states turns off a different set of clock enables. The enables cover the core, the DMA controller, and the timer and serial peripheral groups.

A pending interrupt or a synchronous reset brings the block back to running. When a request leads into standby, the block first sends the peripheral groups a one-cycle update pulse while their clocks are still on. This lets them bring their state up to date before their clocks stop.

Top module: `pwr_state_ctrl`

## Requirements
- R1: A sleep request accepted in running moves the state to standby (code 2'b11) at the next clock edge whenever bit 7 of the first control byte is 1. The second byte makes no difference in that case.
- R2: A sleep request accepted in running moves the state to deep sleep (code 2'b10) at the next edge when bit 7 of the first byte is 0 and bit 7 of the second byte is 1.
- R3: A sleep request accepted in running moves the state to plain sleep (code 2'b01) at the next edge when bit 7 of both bytes is 0. No other bit of either byte has any effect.
- R4: In running (code 2'b00) without a sleep request, the state stays running, whether or not an interrupt is pending.
- R5: In any low-power state, an interrupt pending at a clock edge returns the state to running at that edge.
- R6: A low reset at a clock edge forces running from any state. It also suppresses both sleep entry and the update pulse.
- R7: Clock enables per state (core, DMA, peripherals): running 1,1,1; plain sleep 0,1,1; deep sleep 0,0,1; standby 0,0,0.
- R8: The update pulse is high, for every peripheral group, only in the cycle in which a sleep request that leads into standby is present in running. It is never high for a request that leads to plain or deep sleep.
- R9: A sleep request in a low-power state without a pending interrupt is ignored. The state and the enables stay unchanged.
- R10: A sleep request made in running while an interrupt is already pending still enters the selected low-power state for one cycle. The block returns to running at the following edge if the interrupt is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_req | input | 1 | Sleep instruction executed this cycle |
| stby_ctl_a | input | CTL_W (8) | First standby-control byte, selector at bit SEL_BIT (7) |
| stby_ctl_b | input | CTL_W (8) | Second standby-control byte, selector at bit SEL_BIT (7) |
| irq_pending | input | 1 | Interrupt pending, wake condition |
| state_o | output | 2 | 00 running, 01 sleep, 10 deep sleep, 11 standby |
| core_clk_en | output | 1 | Core clock enable |
| dma_clk_en | output | 1 | DMA controller clock enable |
| periph_clk_en | output | N_PERIPH (2) | Timer and serial group clock enables |
| periph_flush | output | N_PERIPH (2) | Final update pulse before standby |

## Verification
The bench builds the block with its defaults: 8-bit control bytes, the selector at bit 7, and two peripheral groups. With these values the selector bit is the top bit of each byte. The patterns 0x7F and 0x80 can therefore show that only that bit steers the choice. Both groups' enable and update-pulse bits are compared in every cycle. Each low-power state is reached from running. The bench also covers ignored requests, wakes, and reset from each state, as well as entry with an interrupt already pending.

// File: rtl/pwr_state_pkg.sv
// Shared state encoding for the sleep power state controller.
// Assumes a two-bit state code that is visible at the top ports.
package pwr_state_pkg;
    typedef enum logic [1:0] {
        PS_RUN   = 2'b00,
        PS_SLEEP = 2'b01,
        PS_DEEP  = 2'b10,
        PS_STBY  = 2'b11
    } pwr_state_t;
endpackage

// File: rtl/pwr_mode_select.sv
// Chooses the low-power target from the selector bits of the two control bytes.
// Assumes SEL_BIT < CTL_W. The first byte has priority over the second.
module pwr_mode_select
    import pwr_state_pkg::*;
#(
    parameter int CTL_W   = 8,
    parameter int SEL_BIT = 7
) (
    input  logic [CTL_W-1:0] ctl_a,
    input  logic [CTL_W-1:0] ctl_b,
    output pwr_state_t       target
);
    // priority pick: standby, then deep sleep, else plain sleep
    always_comb begin
        if (ctl_a[SEL_BIT])      target = PS_STBY;
        else if (ctl_b[SEL_BIT]) target = PS_DEEP;
        else                     target = PS_SLEEP;
    end
endmodule

// File: rtl/pwr_state_fsm.sv
// Holds the power state and raises the pre-standby update request.
// Assumes irq_pending and sleep_req are synchronous to clk.
module pwr_state_fsm
    import pwr_state_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       irq_pending,
    input  pwr_state_t target,
    output pwr_state_t state,
    output logic       flush_req
);
    pwr_state_t state_nx;

    // next state: enter on request from running, leave on interrupt
    always_comb begin
        state_nx = state;
        if (state == PS_RUN) begin
            if (sleep_req) state_nx = target;
        end else if (irq_pending) begin
            state_nx = PS_RUN;
        end
    end

    // state register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_RUN;
        else        state <= state_nx;
    end

    // final update request while peripheral clocks still run
    always_comb flush_req = rst_n && (state == PS_RUN) && sleep_req && (target == PS_STBY);

    // R1
    stby_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_RUN && sleep_req && target == PS_STBY) |=> state == PS_STBY);
    // R5
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PS_RUN && irq_pending) |=> state == PS_RUN);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PS_RUN && !irq_pending) |=> $stable(state));
    // R4
    stay_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_RUN && !sleep_req) |=> state == PS_RUN);
    // R6
    reset_run_chk: assert property (@(posedge clk)
        !rst_n |=> state == PS_RUN);
    // R8
    flush_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> state == PS_STBY);
endmodule

// File: rtl/pwr_clk_gate_dec.sv
// Turns the power state into clock enables and per-group update pulses.
// Assumes every peripheral group is gated only in standby.
module pwr_clk_gate_dec
    import pwr_state_pkg::*;
#(
    parameter int N_PERIPH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  pwr_state_t          state,
    input  logic                flush_req,
    output logic                core_en,
    output logic                dma_en,
    output logic [N_PERIPH-1:0] periph_en,
    output logic [N_PERIPH-1:0] periph_flush
);
    // core and DMA enables per state
    always_comb begin
        core_en = (state == PS_RUN);
        dma_en  = (state == PS_RUN) || (state == PS_SLEEP);
    end

    // one enable and one update pulse per peripheral group
    for (genvar g = 0; g < N_PERIPH; g++) begin : g_periph
        always_comb begin
            periph_en[g]    = (state != PS_STBY);
            periph_flush[g] = flush_req;
        end
    end

    // R7
    gate_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |-> (dma_en && (&periph_en)));
    // R7
    dma_before_periph_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&periph_en)) |-> !dma_en);
    // R8
    flush_clocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|periph_flush) |-> (core_en && (&periph_en)));
endmodule

// File: rtl/pwr_state_ctrl.sv
// Top of the sleep power state controller: mode choice, state and gating.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module pwr_state_ctrl
    import pwr_state_pkg::*;
#(
    parameter int CTL_W    = 8,
    parameter int SEL_BIT  = 7,
    parameter int N_PERIPH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sleep_req,
    input  logic [CTL_W-1:0]    stby_ctl_a,
    input  logic [CTL_W-1:0]    stby_ctl_b,
    input  logic                irq_pending,
    output logic [1:0]          state_o,
    output logic                core_clk_en,
    output logic                dma_clk_en,
    output logic [N_PERIPH-1:0] periph_clk_en,
    output logic [N_PERIPH-1:0] periph_flush
);
    pwr_state_t target;
    pwr_state_t state;
    logic       flush_req;

    pwr_mode_select #(.CTL_W(CTL_W), .SEL_BIT(SEL_BIT)) u_sel (
        .ctl_a (stby_ctl_a),
        .ctl_b (stby_ctl_b),
        .target(target)
    );

    pwr_state_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .irq_pending(irq_pending),
        .target     (target),
        .state      (state),
        .flush_req  (flush_req)
    );

    pwr_clk_gate_dec #(.N_PERIPH(N_PERIPH)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .flush_req   (flush_req),
        .core_en     (core_clk_en),
        .dma_en      (dma_clk_en),
        .periph_en   (periph_clk_en),
        .periph_flush(periph_flush)
    );

    // expose the state code
    always_comb state_o = state;
endmodule

// File: tb/tb_pwr_state_ctrl.sv
module tb_pwr_state_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic [7:0] ctl_a = 8'h00;
    logic [7:0] ctl_b = 8'h00;
    logic       irq = 1'b0;
    logic [1:0] state_o;
    logic       core_en, dma_en;
    logic [1:0] per_en, per_flush;

    int total = 0;
    int bad = 0;
    logic [1:0] model = 2'b00;
    logic [1:0] expq[$];
    string      tagq[$];
    bit         done = 1'b0;

    always #2 clk = ~clk;

    pwr_state_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .stby_ctl_a(ctl_a), .stby_ctl_b(ctl_b), .irq_pending(irq),
        .state_o(state_o), .core_clk_en(core_en), .dma_clk_en(dma_en),
        .periph_clk_en(per_en), .periph_flush(per_flush)
    );

    // enables expected per state (R7): {core, dma, periph group bits}
    function automatic logic [3:0] en_of(input logic [1:0] s);
        case (s)
            2'b00:   en_of = 4'b1111;
            2'b01:   en_of = 4'b0111;
            2'b10:   en_of = 4'b0011;
            default: en_of = 4'b0000;
        endcase
    endfunction

    // driver: apply inputs, check update pulse, push expected next state
    task automatic step(input logic r, input logic sr, input logic [7:0] a,
                        input logic [7:0] b, input logic ir, input string tag);
        logic [1:0] nx;
        logic       fl;
        @(negedge clk);
        rst_n = r; sleep_req = sr; ctl_a = a; ctl_b = b; irq = ir;
        fl = r && model == 2'b00 && sr && a[7];
        if (!r)                 nx = 2'b00;
        else if (model == 2'b00) nx = sr ? (a[7] ? 2'b11 : (b[7] ? 2'b10 : 2'b01)) : 2'b00;
        else                    nx = ir ? 2'b00 : model;
        #1;
        total++;
        if (per_flush !== {fl, fl}) begin
            bad++;
            $display("FAIL %s R8 flush=%b expected %b", tag, per_flush, {fl, fl});
        end
        model = nx;
        expq.push_back(nx);
        tagq.push_back(tag);
    endtask

    // monitor: compare state and enables after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (expq.size() > 0) begin
                logic [1:0] e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                total++;
                if (state_o !== e || {core_en, dma_en, per_en} !== en_of(e)) begin
                    bad++;
                    $display("FAIL %s R7 state=%b en=%b expected state=%b en=%b",
                             t, state_o, {core_en, dma_en, per_en}, e, en_of(e));
                end
            end
        end
    end

    initial begin
        step(0, 0, 8'h00, 8'h00, 0, "R6 reset");
        step(0, 1, 8'h80, 8'h80, 1, "R6 reset blocks request");
        step(1, 0, 8'hFF, 8'hFF, 1, "R4 irq in running");
        step(1, 0, 8'h00, 8'h00, 0, "R4 idle");
        step(1, 1, 8'h7F, 8'h7F, 0, "R3 plain sleep");
        step(1, 1, 8'h80, 8'h80, 0, "R9 request ignored");
        step(1, 0, 8'h00, 8'h00, 0, "R9 hold");
        step(1, 0, 8'h00, 8'h00, 1, "R5 wake sleep");
        step(1, 1, 8'h7F, 8'hFF, 0, "R2 deep sleep");
        step(1, 1, 8'h80, 8'h00, 0, "R9 deep ignore");
        step(1, 0, 8'h00, 8'h00, 1, "R5 wake deep");
        step(1, 1, 8'h80, 8'h00, 0, "R1 standby");
        step(1, 1, 8'h00, 8'h00, 0, "R9 standby ignore");
        step(1, 0, 8'h00, 8'h00, 1, "R5 wake standby");
        step(1, 1, 8'hFF, 8'h7F, 1, "R10 standby with irq");
        step(1, 0, 8'h00, 8'h00, 1, "R10 wake next");
        step(1, 1, 8'h00, 8'h80, 1, "R10 deep with irq");
        step(1, 0, 8'h00, 8'h00, 1, "R10 deep wake");
        for (int k = 0; k < 3; k++) begin
            step(1, 1, (k == 2) ? 8'h80 : 8'h00, (k == 1) ? 8'h80 : 8'h00, 0, "R1 R2 R3 entry");
            step(0, 0, 8'h00, 8'h00, 0, "R6 reset from low power");
            step(1, 0, 8'h00, 8'h00, 0, "R4 after reset");
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog R5 run did not end, expected completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule